// File: doc/BRIEF.md
# Register Scoreboard with Dependent Wakeup

This block keeps one readiness bit for every physical register, across the integer and floating-point files, and holds instructions that wait for source operands. An instruction enters with an identifier, a set of class flags, its source register indices and one destination register index. Each source is resolved when the instruction enters. A source whose register is already ready, or whose register completes in that same cycle, is marked ready at once. Any other source waits for a completion broadcast that carries its register index. When the instruction enters, its destination bit is cleared, so the instruction is the outstanding producer of that register.

A completion broadcast carries one destination register per cycle. It sets that register's readiness bit. It also marks ready every waiting source that names the register, in every held slot. A held instruction whose sources are all ready is released, one per cycle. It appears on the output of the ready pool that its class flags select: branch, memory, integer, floating point or misc. Register indices at or above the physical register count name control and miscellaneous registers, and the block does not track them.

Top module: `regsb_wakeup`

## Requirements
- R1: After reset, every readiness bit is 0, no slot is held, no pool output is valid and err_o is 0.
- R2: A source index at or above NPREG counts as ready on insert. A destination index at or above NPREG leaves every readiness bit unchanged and never raises err_o.
- R3: On insert, a tracked source is ready when its readiness bit is 1, or when a completion for that register arrives in the same cycle. Otherwise the source waits.
- R4: An accepted insert clears its tracked destination's readiness bit from the next cycle on. This takes precedence over a completion of the same register in the same cycle.
- R5: A completion of a tracked register sets its readiness bit from the next cycle on. It also marks ready every unready source that names that register, in every held slot.
- R6: err_o is 1 in the cycle of an accepted insert when all of the following hold: the destination is tracked, some held slot has an unready source naming that destination, and no completion of that register arrives in the same cycle.
- R7: At most one held instruction is released per cycle. The lowest-index slot whose sources are all ready is released. An instruction shows on the output in the cycle after its last source became ready, and its slot is free from the next cycle on.
- R8: ins_kind_i bit 3 means control, bit 2 memory, bit 1 integer and bit 0 floating point. The pool is picked in that order of priority: iss_valid_o bit 0 for control, bit 1 for memory, bit 2 for integer, bit 3 for floating point, and bit 4 when no flag is set. iss_id_o carries the released identifier.
- R9: An insert takes the lowest-index free slot. full_o is 1 while all DEPTH slots are held, and an insert presented while full_o is 1 is ignored.
- R10: A source that has been marked ready in a held slot stays ready until the slot is released, even if its register is later cleared by a new producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_id_i | input | IDW | Identifier of the inserted instruction |
| ins_kind_i | input | 4 | Class flags: control, memory, integer, floating point |
| ins_src_i | input | NSRC*PRW | Source register indices, source 0 in the low bits |
| ins_dst_i | input | PRW | Destination register index |
| cmp_valid_i | input | 1 | Completion broadcast valid |
| cmp_dst_i | input | PRW | Destination register of the completing producer |
| full_o | output | 1 | All slots held |
| err_o | output | 1 | Destination inserted while waiters exist on it |
| sb_o | output | NPREG | Readiness bit of each physical register |
| iss_valid_o | output | 5 | Ready pool strobes: branch, memory, integer, float, misc |
| iss_id_o | output | IDW | Identifier of the released instruction |

## Verification
The insert and the completion broadcast can fall in the same cycle and name the same register. The two can meet in two ways. A source of the inserted instruction may name the completing register, and then the source must be taken as ready through the bypass. The destination may name it, and then the clear must win over the set and no error may be raised. Directed cases force both collisions. In the random phase both ports draw from a pool of eight registers, so collisions occur often. A bench model, written from the requirements, predicts for every cycle the pool strobe, the identifier, err_o, full_o and the whole readiness vector, and these are compared with the outputs.

// File: rtl/regsb_pkg.sv
`timescale 1ns/1ps
package regsb_pkg;
  localparam int NPOOL = 5;

  typedef enum logic [2:0] {
    POOL_BR   = 3'd0,
    POOL_MEM  = 3'd1,
    POOL_INT  = 3'd2,
    POOL_FP   = 3'd3,
    POOL_MISC = 3'd4
  } pool_e;

  // kind bits: [3] control, [2] memory, [1] integer, [0] float
  function automatic pool_e steer(input logic [3:0] kind);
    if (kind[3])      return POOL_BR;
    else if (kind[2]) return POOL_MEM;
    else if (kind[1]) return POOL_INT;
    else if (kind[0]) return POOL_FP;
    else              return POOL_MISC;
  endfunction
endpackage

// File: rtl/regsb_table.sv
`timescale 1ns/1ps
module regsb_table #(
  parameter int NPREG = 48,
  parameter int PRW   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_v_i,
  input  logic [PRW-1:0]   set_idx_i,
  input  logic             clr_v_i,
  input  logic [PRW-1:0]   clr_idx_i,
  output logic [NPREG-1:0] ready_o
);
  logic [NPREG-1:0] rdy_q;

  for (genvar r = 0; r < NPREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rdy_q[r] <= 1'b0;
      else if (clr_v_i && clr_idx_i == PRW'(r))   rdy_q[r] <= 1'b0;
      else if (set_v_i && set_idx_i == PRW'(r))   rdy_q[r] <= 1'b1;
    end
  end

  assign ready_o = rdy_q;

  assert_set_on_complete_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_v_i && !(clr_v_i && clr_idx_i == set_idx_i) |=> ready_o[$past(set_idx_i)]);

  assert_clear_on_insert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_v_i |=> !ready_o[$past(clr_idx_i)]);
endmodule

// File: rtl/regsb_slot.sv
`timescale 1ns/1ps
module regsb_slot #(
  parameter int NSRC = 2,
  parameter int PRW  = 6,
  parameter int IDW  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  logic [NSRC-1:0][PRW-1:0]  src_i,
  input  logic [NSRC-1:0]           src_rdy_i,
  input  logic [IDW-1:0]            id_i,
  input  logic [2:0]                pool_i,
  input  logic                      wake_v_i,
  input  logic [PRW-1:0]            wake_idx_i,
  input  logic                      free_i,
  input  logic [PRW-1:0]            qry_idx_i,
  output logic                      valid_o,
  output logic                      ready_o,
  output logic                      hit_o,
  output logic [IDW-1:0]            id_o,
  output logic [2:0]                pool_o
);
  logic                     v_q;
  logic [NSRC-1:0][PRW-1:0] src_q;
  logic [NSRC-1:0]          rdy_q;
  logic [IDW-1:0]           id_q;
  logic [2:0]               pool_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      src_q  <= '0;
      rdy_q  <= '0;
      id_q   <= '0;
      pool_q <= '0;
    end else if (alloc_i) begin
      v_q    <= 1'b1;
      src_q  <= src_i;
      rdy_q  <= src_rdy_i;
      id_q   <= id_i;
      pool_q <= pool_i;
    end else begin
      if (free_i) v_q <= 1'b0;
      for (int k = 0; k < NSRC; k++)
        if (wake_v_i && src_q[k] == wake_idx_i) rdy_q[k] <= 1'b1;
    end
  end

  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (!rdy_q[k] && src_q[k] == qry_idx_i) hit_o = v_q;
  end

  assign valid_o = v_q;
  assign ready_o = v_q && (&rdy_q);
  assign id_o    = id_q;
  assign pool_o  = pool_q;

  assert_alloc_free_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && v_q));

  assert_release_only_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> ready_o);

  for (genvar k = 0; k < NSRC; k++) begin : g_hold
    assert_ready_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q && rdy_q[k] && !free_i |=> rdy_q[k]);
  end
endmodule

// File: rtl/regsb_pick.sv
`timescale 1ns/1ps
module regsb_pick
  import regsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDW   = 8
) (
  input  logic [DEPTH-1:0]           cand_i,
  input  logic [DEPTH-1:0][IDW-1:0]  id_i,
  input  logic [DEPTH-1:0][2:0]      pool_i,
  output logic [DEPTH-1:0]           grant_o,
  output logic [NPOOL-1:0]           iss_valid_o,
  output logic [IDW-1:0]             iss_id_o
);
  logic [2:0] sel_pool;

  always_comb begin
    grant_o  = '0;
    iss_id_o = '0;
    sel_pool = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (cand_i[i]) begin
        grant_o  = '0;
        grant_o[i] = 1'b1;
        iss_id_o = id_i[i];
        sel_pool = pool_i[i];
      end
    end
    for (int p = 0; p < NPOOL; p++)
      iss_valid_o[p] = (|cand_i) && sel_pool == 3'(p);
  end
endmodule

// File: rtl/regsb_wakeup.sv
`timescale 1ns/1ps
module regsb_wakeup
  import regsb_pkg::*;
#(
  parameter int NPREG = 48,
  parameter int PRW   = 6,
  parameter int NSRC  = 2,
  parameter int DEPTH = 8,
  parameter int IDW   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_valid_i,
  input  logic [IDW-1:0]       ins_id_i,
  input  logic [3:0]           ins_kind_i,
  input  logic [NSRC*PRW-1:0]  ins_src_i,
  input  logic [PRW-1:0]       ins_dst_i,
  input  logic                 cmp_valid_i,
  input  logic [PRW-1:0]       cmp_dst_i,
  output logic                 full_o,
  output logic                 err_o,
  output logic [NPREG-1:0]     sb_o,
  output logic [NPOOL-1:0]     iss_valid_o,
  output logic [IDW-1:0]       iss_id_o
);
  localparam int SLOTW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NIDX  = 2 ** PRW;

  function automatic logic tracked(input logic [PRW-1:0] r);
    return {1'b0, r} < (PRW+1)'(NPREG);
  endfunction

  logic [NPREG-1:0]           sb;
  logic [NIDX-1:0]            sb_ext;
  logic [NSRC-1:0][PRW-1:0]   src;
  logic [NSRC-1:0]            src_rdy;
  logic                       cmp_tr, fire, any_free, dst_tr;
  logic [SLOTW-1:0]           free_idx;
  logic [DEPTH-1:0]           valid, rdy, hit, alloc, grant;
  logic [DEPTH-1:0][IDW-1:0]  ids;
  logic [DEPTH-1:0][2:0]      pools;
  logic [2:0]                 ins_pool;

  assign src      = ins_src_i;
  assign sb_ext   = NIDX'(sb);
  assign cmp_tr   = cmp_valid_i && tracked(cmp_dst_i);
  assign dst_tr   = tracked(ins_dst_i);
  assign ins_pool = steer(ins_kind_i);

  // same-cycle completion bypass into the inserted sources
  always_comb begin
    for (int k = 0; k < NSRC; k++)
      src_rdy[k] = !tracked(src[k]) || sb_ext[src[k]] ||
                   (cmp_tr && cmp_dst_i == src[k]);
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = SLOTW'(i);
      end
    end
  end

  assign full_o = !any_free;
  assign fire   = ins_valid_i && any_free;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign alloc[i] = fire && free_idx == SLOTW'(i);
    regsb_slot #(.NSRC(NSRC), .PRW(PRW), .IDW(IDW)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc[i]),
      .src_i      (src),
      .src_rdy_i  (src_rdy),
      .id_i       (ins_id_i),
      .pool_i     (ins_pool),
      .wake_v_i   (cmp_tr),
      .wake_idx_i (cmp_dst_i),
      .free_i     (grant[i]),
      .qry_idx_i  (ins_dst_i),
      .valid_o    (valid[i]),
      .ready_o    (rdy[i]),
      .hit_o      (hit[i]),
      .id_o       (ids[i]),
      .pool_o     (pools[i])
    );
  end

  regsb_pick #(.DEPTH(DEPTH), .IDW(IDW)) u_pick (
    .cand_i      (rdy),
    .id_i        (ids),
    .pool_i      (pools),
    .grant_o     (grant),
    .iss_valid_o (iss_valid_o),
    .iss_id_o    (iss_id_o)
  );

  regsb_table #(.NPREG(NPREG), .PRW(PRW)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_v_i   (cmp_tr),
    .set_idx_i (cmp_dst_i),
    .clr_v_i   (fire && dst_tr),
    .clr_idx_i (ins_dst_i),
    .ready_o   (sb)
  );

  assign sb_o  = sb;
  assign err_o = fire && dst_tr && (|hit) && !(cmp_tr && cmp_dst_i == ins_dst_i);

  assert_single_pool_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(iss_valid_o));

  assert_slot_filled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> valid[$past(free_idx)]);

  assert_full_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !(|grant) |=> full_o);

  assert_untracked_dst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && !dst_tr |-> !err_o);
endmodule

// File: tb/tb_regsb_wakeup.sv
`timescale 1ns/1ps
module tb_regsb_wakeup;
  localparam int NPREG = 48;
  localparam int PRW   = 6;
  localparam int NSRC  = 2;
  localparam int DEPTH = 8;
  localparam int IDW   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid;
  logic [IDW-1:0] ins_id;
  logic [3:0] ins_kind;
  logic [NSRC*PRW-1:0] ins_src;
  logic [PRW-1:0] ins_dst;
  logic cmp_valid;
  logic [PRW-1:0] cmp_dst;
  logic full, err;
  logic [NPREG-1:0] sb;
  logic [4:0] iss_valid;
  logic [IDW-1:0] iss_id;

  always #2.5 clk = ~clk;

  regsb_wakeup #(.NPREG(NPREG), .PRW(PRW), .NSRC(NSRC), .DEPTH(DEPTH), .IDW(IDW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_valid), .ins_id_i(ins_id),
    .ins_kind_i(ins_kind), .ins_src_i(ins_src), .ins_dst_i(ins_dst),
    .cmp_valid_i(cmp_valid), .cmp_dst_i(cmp_dst), .full_o(full), .err_o(err),
    .sb_o(sb), .iss_valid_o(iss_valid), .iss_id_o(iss_id));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  bit             m_v   [DEPTH];
  logic [IDW-1:0] m_id  [DEPTH];
  int             m_pool[DEPTH];
  logic [PRW-1:0] m_src [DEPTH][NSRC];
  bit             m_rdy [DEPTH][NSRC];
  bit             m_sb  [NPREG];

  logic [4:0]       obs_iss;
  logic [IDW-1:0]   obs_id;
  logic             obs_err, obs_full;
  logic [NPREG-1:0] obs_sb;

  function automatic int pool_of(input logic [3:0] k);
    if (k[3]) return 0;
    if (k[2]) return 1;
    if (k[1]) return 2;
    if (k[0]) return 3;
    return 4;
  endfunction

  function automatic bit trk(input logic [PRW-1:0] r);
    return int'(r) < NPREG;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [3:0] kd, input logic [IDW-1:0] id,
                      input logic [PRW-1:0] s0, input logic [PRW-1:0] s1,
                      input logic [PRW-1:0] d, input logic cv, input logic [PRW-1:0] cd);
    int sel, slot;
    bit efull, fire, ctr, eerr;
    logic [4:0] eiss;
    logic [IDW-1:0] eid;
    logic [NPREG-1:0] esb;
    logic [PRW-1:0] s [NSRC];
    @(negedge clk);
    ins_valid = iv; ins_kind = kd; ins_id = id; ins_src = {s1, s0}; ins_dst = d;
    cmp_valid = cv; cmp_dst = cd;
    #1;
    s[0] = s0; s[1] = s1;
    sel = -1; slot = -1; efull = 1'b1;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (m_v[i] && m_rdy[i][0] && m_rdy[i][1]) sel = i;
      if (!m_v[i]) begin slot = i; efull = 1'b0; end
    end
    eiss = '0; eid = '0;
    if (sel >= 0) begin eiss[m_pool[sel]] = 1'b1; eid = m_id[sel]; end
    fire = iv && !efull;
    ctr  = cv && trk(cd);
    eerr = 1'b0;
    if (fire && trk(d) && !(ctr && cd == d))
      for (int i = 0; i < DEPTH; i++)
        for (int k = 0; k < NSRC; k++)
          if (m_v[i] && !m_rdy[i][k] && m_src[i][k] == d) eerr = 1'b1;
    for (int r = 0; r < NPREG; r++) esb[r] = m_sb[r];
    obs_iss = iss_valid; obs_id = iss_id; obs_err = err; obs_full = full; obs_sb = sb;
    check(iss_valid == eiss, "R7 R8 pool strobe", longint'(iss_valid), longint'(eiss));
    if (sel >= 0) check(iss_id == eid, "R7 R8 released id", longint'(iss_id), longint'(eid));
    check(err == eerr, "R6 err", longint'(err), longint'(eerr));
    check(full == efull, "R9 full", longint'(full), longint'(efull));
    check(sb == esb, "R4 R5 readiness vector", longint'(sb), longint'(esb));
    @(posedge clk);
    if (sel >= 0) m_v[sel] = 1'b0;
    if (ctr)
      for (int i = 0; i < DEPTH; i++)
        for (int k = 0; k < NSRC; k++)
          if (m_src[i][k] == cd) m_rdy[i][k] = 1'b1;
    if (fire) begin
      m_v[slot] = 1'b1; m_id[slot] = id; m_pool[slot] = pool_of(kd);
      for (int k = 0; k < NSRC; k++) begin
        m_src[slot][k] = s[k];
        m_rdy[slot][k] = !trk(s[k]) || m_sb[int'(s[k])] || (ctr && cd == s[k]);
      end
    end
    if (ctr) m_sb[int'(cd)] = 1'b1;
    if (fire && trk(d)) m_sb[int'(d)] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, '0, '0, '0, '0, 1'b0, '0);
  endtask

  task automatic ins(input logic [3:0] kd, input logic [IDW-1:0] id, input logic [PRW-1:0] s0,
                     input logic [PRW-1:0] s1, input logic [PRW-1:0] d);
    step(1'b1, kd, id, s0, s1, d, 1'b0, '0);
  endtask

  task automatic comp(input logic [PRW-1:0] cd);
    step(1'b0, 4'h0, '0, '0, '0, '0, 1'b1, cd);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NPREG-1:0] sb_keep;
    bit saw99;
    logic [IDW-1:0] rid;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ins_valid = 0; ins_id = 0; ins_kind = 0; ins_src = 0; ins_dst = 0;
    cmp_valid = 0; cmp_dst = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_id[i] = 0; m_pool[i] = 0;
      for (int k = 0; k < NSRC; k++) begin m_src[i][k] = 0; m_rdy[i][k] = 0; end
    end
    for (int r = 0; r < NPREG; r++) m_sb[r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    check(sb == '0, "R1 readiness after reset", longint'(sb), 0);
    check(iss_valid == '0, "R1 no release after reset", longint'(iss_valid), 0);
    check(!full && !err, "R1 full/err after reset", longint'({full, err}), 0);

    // R5 wakeup of a waiter by two completions
    ins(4'b0010, 8'd1, 6'd1, 6'd2, 6'd10);
    comp(6'd1);
    comp(6'd2);
    idle(1);
    check(obs_iss == 5'b00100 && obs_id == 8'd1, "R5 waiter released after wake",
          longint'({obs_iss, obs_id}), longint'({5'b00100, 8'd1}));

    // R3 ready sources at insert, R8 control beats integer
    ins(4'b1010, 8'd2, 6'd1, 6'd2, 6'd11);
    idle(1);
    check(obs_iss == 5'b00001 && obs_id == 8'd2, "R3 R8 immediate release to branch pool",
          longint'({obs_iss, obs_id}), longint'({5'b00001, 8'd2}));

    // R3 same-cycle completion bypass, R2 untracked source
    step(1'b1, 4'b0110, 8'd3, 6'd11, 6'd50, 6'd12, 1'b1, 6'd11);
    idle(1);
    check(obs_iss == 5'b00010 && obs_id == 8'd3, "R3 R2 bypass plus untracked source",
          longint'({obs_iss, obs_id}), longint'({5'b00010, 8'd3}));

    // R2 untracked destination
    sb_keep = sb;
    ins(4'b0000, 8'd4, 6'd60, 6'd61, 6'd62);
    idle(1);
    check(obs_iss == 5'b10000 && obs_id == 8'd4, "R2 misc release", longint'({obs_iss, obs_id}),
          longint'({5'b10000, 8'd4}));
    check(obs_sb == sb_keep && !obs_err, "R2 readiness untouched", longint'(obs_sb), longint'(sb_keep));

    // R4 insert clear beats same-cycle completion
    step(1'b1, 4'b0001, 8'd5, 6'd1, 6'd2, 6'd20, 1'b1, 6'd20);
    idle(1);
    check(obs_sb[20] == 1'b0, "R4 clear wins", longint'(obs_sb[20]), 0);
    idle(2);

    // R6 producer inserted while a waiter exists
    ins(4'b0010, 8'd6, 6'd21, 6'd1, 6'd30);
    ins(4'b0010, 8'd7, 6'd1, 6'd1, 6'd21);
    check(obs_err == 1'b1, "R6 error raised", longint'(obs_err), 1);
    comp(6'd21);
    ins(4'b0010, 8'd8, 6'd22, 6'd1, 6'd31);
    step(1'b1, 4'b0010, 8'd9, 6'd1, 6'd1, 6'd22, 1'b1, 6'd22);
    check(obs_err == 1'b0, "R6 no error when completion empties the waiters", longint'(obs_err), 0);
    idle(6);

    // R10 ready source survives a new producer of its register
    ins(4'b0010, 8'd10, 6'd2, 6'd23, 6'd32);
    ins(4'b0010, 8'd11, 6'd1, 6'd1, 6'd2);
    comp(6'd23);
    idle(1);
    check(obs_iss == 5'b00100 && obs_id == 8'd10, "R10 sticky source", longint'({obs_iss, obs_id}),
          longint'({5'b00100, 8'd10}));
    idle(3);

    // R9 fill to full, insert while full ignored, drain in slot order
    for (int i = 0; i < DEPTH; i++) ins(4'b0001, IDW'(40 + i), 6'd40, 6'd1, PRW'(24 + i));
    ins(4'b0001, 8'd99, 6'd1, 6'd1, 6'd35);
    check(obs_full == 1'b1, "R9 full while all slots held", longint'(obs_full), 1);
    comp(6'd40);
    saw99 = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      idle(1);
      if (obs_iss != 0 && obs_id == 8'd99) saw99 = 1'b1;
    end
    check(!saw99, "R9 insert while full ignored", longint'(saw99), 0);

    // random phase
    rid = 8'd100;
    for (int n = 0; n < 4000; n++) begin
      logic [PRW-1:0] rs [3];
      logic [PRW-1:0] rc;
      for (int j = 0; j < 3; j++) begin
        int v = int'($urandom % 10);
        rs[j] = (v < 8) ? PRW'(v) : PRW'(48 + int'($urandom % 16));
      end
      rc = ($urandom % 10 < 9) ? PRW'($urandom % 8) : PRW'(48 + int'($urandom % 16));
      step(1'($urandom % 3 != 0), 4'($urandom), rid, rs[0], rs[1], rs[2],
           1'($urandom % 2), rc);
      rid++;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule